// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block sits on the read side of a synchronous DRAM column path. A READ command arrives with a starting column address. At that moment the block samples a mode setting, made of a burst-length code, a burst-order select and a CAS-latency code. It then presents one column address per clock for every beat of the burst. The low column bits that the burst length selects are reordered, either by counting upward and wrapping inside the burst boundary, or by XOR with the beat index. All higher column bits pass through unchanged.

Two strobes frame the burst. The data-bus drive enable rises one clock ahead of the first valid beat. The data-valid strobe rises after the programmed number of clocks. Both strobes drop together after the last beat. A READ that carries a reserved mode code starts no burst and raises a one-cycle error flag. While a burst or its latency wait is in progress, `busy` is high and further READs are ignored.

Top module: `sdram_rd_seq`

## Requirements
- R1: With `burst_il`=0 (sequential order), beat k presents the low burst bits equal to (start + k) modulo the burst length. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R2: With `burst_il`=1 (interleaved order), beat k presents the low burst bits equal to start XOR k. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R3: Only column bit 0 (2 beats), bits 1:0 (4 beats) or bits 2:0 (8 beats) are reordered. Every higher bit of `col_out` equals the same bit of the READ column on every beat.
- R4: `bl_code` 3'b001, 3'b010 and 3'b011 select 2, 4 and 8 beats. `cl_code` 2'b10 and 2'b11 select a latency m of 2 and 3. Count the clock edge that registers the READ as edge 0. `dq_valid` then rises as a result of edge m, and `col_out` presents beat 0 at that point.
- R5: `dq_oe` rises as a result of edge m-1, one cycle before `dq_valid`. It stays high while `dq_valid` is high.
- R6: `dq_valid` stays high for exactly burst-length consecutive cycles, with one beat per cycle. `dq_oe` and `dq_valid` drop in the same cycle.
- R7: A READ registered while idle is rejected if `bl_code` is any value other than 001, 010 or 011, or if `cl_code` is 00 or 01. A rejected READ makes `mode_err` high for exactly one cycle. It leaves `busy`, `dq_oe` and `dq_valid` low.
- R8: `busy` is high from the cycle after the READ is registered through the last valid beat. A READ presented while `busy` is high is ignored: the burst in flight is unchanged and `mode_err` stays low.
- R9: The mode inputs are sampled only at the READ edge. A change to them during a burst does not alter that burst's order, length or timing.
- R10: After reset, and whenever `dq_valid` is low, `col_out` is 0. After reset, `dq_oe`, `dq_valid`, `busy` and `mode_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | READ command, registered on the rising edge |
| rd_col | input | COL_W | Starting column address |
| bl_code | input | 3 | Burst-length code |
| burst_il | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cl_code | input | 2 | CAS-latency code |
| col_out | output | COL_W | Column address of the current beat |
| dq_oe | output | 1 | Data-bus drive enable |
| dq_valid | output | 1 | Data-valid strobe, one beat per cycle |
| busy | output | 1 | Burst or latency wait in progress |
| mode_err | output | 1 | One-cycle flag for a rejected READ |

## Verification
A corrupted latency counter moves the rising edge of `dq_oe` or `dq_valid` off its expected cycle. It therefore shows on the first burst with that latency, within three cycles of the READ. A wrong beat counter or length mask gives a burst with the wrong number of valid cycles, or a wrong low-bit pattern from the second beat onward. A mode register that is not frozen at the READ edge shows up because the bench changes every mode input right after each READ. Sweeping every start value across both orders, all three lengths and both latencies makes sure that any wrong column appears on the beat where it occurs.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int unsigned ORD_W = 3;
    localparam int unsigned LAT_W = 2;

    typedef enum logic [2:0] {
        BLC_2 = 3'b001,
        BLC_4 = 3'b010,
        BLC_8 = 3'b011
    } blc_e;

    typedef enum logic [1:0] {
        CLC_2 = 2'b10,
        CLC_3 = 2'b11
    } clc_e;

endpackage

// File: rtl/rdseq_mode_dec.sv
module rdseq_mode_dec
    import rdseq_pkg::*;
(
    input  logic [2:0]       bl_code,
    input  logic [1:0]       cl_code,
    output logic             legal,
    output logic [ORD_W-1:0] last_beat,
    output logic [LAT_W-1:0] wait_cnt
);
    logic bl_ok;
    logic cl_ok;

    always_comb begin
        bl_ok     = 1'b1;
        last_beat = '0;
        case (bl_code)
            BLC_2:   last_beat = ORD_W'(1);
            BLC_4:   last_beat = ORD_W'(3);
            BLC_8:   last_beat = ORD_W'(7);
            default: bl_ok     = 1'b0;
        endcase
    end

    always_comb begin
        cl_ok    = 1'b1;
        wait_cnt = '0;
        case (cl_code)
            CLC_2:   wait_cnt = LAT_W'(1);
            CLC_3:   wait_cnt = LAT_W'(2);
            default: cl_ok    = 1'b0;
        endcase
    end

    assign legal = bl_ok && cl_ok;

endmodule

// File: rtl/rdseq_order.sv
module rdseq_order
    import rdseq_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [ORD_W-1:0] beat,
    input  logic [ORD_W-1:0] span,
    input  logic             il,
    output logic [COL_W-1:0] col
);
    logic [ORD_W-1:0] low;

    always_comb begin
        if (il) low = base[ORD_W-1:0] ^ beat;
        else    low = base[ORD_W-1:0] + beat;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < ORD_W) begin : g_low
            assign col[i] = span[i] ? low[i] : base[i];
        end else begin : g_high
            assign col[i] = base[i];
        end
    end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import rdseq_pkg::*;
#(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_cmd,
    input  logic [COL_W-1:0] rd_col,
    input  logic [2:0]       bl_code,
    input  logic             burst_il,
    input  logic [1:0]       cl_code,
    output logic [COL_W-1:0] col_out,
    output logic             dq_oe,
    output logic             dq_valid,
    output logic             busy,
    output logic             mode_err
);
    typedef struct packed {
        logic             busy;
        logic             oe;
        logic             valid;
        logic             err;
        logic [LAT_W-1:0] wcnt;
        logic [ORD_W-1:0] beat;
        logic [ORD_W-1:0] last;
        logic             il;
        logic [COL_W-1:0] col;
    } st_t;

    st_t              st_d, st_q;
    logic             dec_legal;
    logic [ORD_W-1:0] dec_last;
    logic [LAT_W-1:0] dec_wait;
    logic [COL_W-1:0] ord_col;

    rdseq_mode_dec u_dec (
        .bl_code   (bl_code),
        .cl_code   (cl_code),
        .legal     (dec_legal),
        .last_beat (dec_last),
        .wait_cnt  (dec_wait)
    );

    rdseq_order #(.COL_W(COL_W)) u_ord (
        .base (st_q.col),
        .beat (st_q.beat),
        .span (st_q.last),
        .il   (st_q.il),
        .col  (ord_col)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (!st_q.busy) begin
            if (rd_cmd) begin
                if (dec_legal) begin
                    st_d.busy = 1'b1;
                    st_d.wcnt = dec_wait;
                    st_d.last = dec_last;
                    st_d.il   = burst_il;
                    st_d.col  = rd_col;
                    st_d.beat = '0;
                end else begin
                    st_d.err  = 1'b1;
                end
            end
        end else if (!st_q.oe) begin
            if (st_q.wcnt == LAT_W'(1)) st_d.oe   = 1'b1;
            else                        st_d.wcnt = st_q.wcnt - LAT_W'(1);
        end else if (!st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.beat  = '0;
        end else if (st_q.beat == st_q.last) begin
            st_d.valid = 1'b0;
            st_d.oe    = 1'b0;
            st_d.busy  = 1'b0;
        end else begin
            st_d.beat = st_q.beat + ORD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_out  = st_q.valid ? ord_col : '0;
    assign dq_oe    = st_q.oe;
    assign dq_valid = st_q.valid;
    assign busy     = st_q.busy;
    assign mode_err = st_q.err;

    p_valid_in_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dq_oe);

    p_oe_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |=> $rose(dq_valid));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_valid) |-> !dq_oe);

    p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> busy);

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_cmd) |=> !mode_err);

    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!busy && !dq_oe));

    p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && $past(dq_valid)) |->
        (col_out[COL_W-1:ORD_W] == $past(col_out[COL_W-1:ORD_W])));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_valid |-> (col_out == '0));

endmodule

// File: tb/sim_sdram_rd_seq.sv
`timescale 1ns/1ps
module sim_sdram_rd_seq;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_cmd = 1'b0;
    logic [CW-1:0] rd_col = '0;
    logic [2:0]    bl_code = 3'b001;
    logic          burst_il = 1'b0;
    logic [1:0]    cl_code = 2'b10;
    logic [CW-1:0] col_out;
    logic          dq_oe, dq_valid, busy, mode_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sdram_rd_seq #(.COL_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_col(rd_col),
        .bl_code(bl_code), .burst_il(burst_il), .cl_code(cl_code),
        .col_out(col_out), .dq_oe(dq_oe), .dq_valid(dq_valid),
        .busy(busy), .mode_err(mode_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int c, input int bl, input bit il, input int b);
        int msk = bl - 1;
        int lo = il ? ((c & msk) ^ b) : (((c & msk) + b) & msk);
        return (c & ~msk) | lo;
    endfunction

    // R1 R2 R3 R4 R5 R6 R8 R9: one burst with scrambled mode and an ignored READ
    task automatic run_burst(input int bsel, input bit il, input bit csel,
                             input int start, input int upper);
        int bl = 2 << bsel;
        int m  = csel ? 3 : 2;
        int c  = (upper << 3) | start;
        @(negedge clk);
        rd_cmd   = 1'b1;
        rd_col   = CW'(c);
        bl_code  = 3'(bsel + 1);
        burst_il = il;
        cl_code  = csel ? 2'b11 : 2'b10;
        for (int k = 0; k <= m + bl; k++) begin
            bit ev = (k >= m) && (k <= m + bl - 1);
            @(negedge clk);
            chk("R8 busy", int'(busy), int'(k <= m + bl - 1));
            chk("R5 dq_oe", int'(dq_oe), int'((k >= m - 1) && (k <= m + bl - 1)));
            chk("R4 R6 dq_valid", int'(dq_valid), int'(ev));
            chk(il ? "R2 R3 col_out" : "R1 R3 col_out", int'(col_out),
                ev ? exp_col(c, bl, il, k - m) : 0);
            chk("R8 mode_err", int'(mode_err), 0);
            if (k == 0) begin
                rd_cmd   = 1'b0;
                bl_code  = (bsel == 2) ? 3'b001 : 3'b011;  // R9 scramble
                burst_il = ~il;
                cl_code  = csel ? 2'b10 : 2'b11;
            end
            if (k == 1) begin
                rd_cmd = 1'b1;                             // R8 ignored READ
                rd_col = ~CW'(c);
            end
            if (k == 2) rd_cmd = 1'b0;
        end
    endtask

    // R7: a rejected READ
    task automatic bad_read(input logic [2:0] blc, input logic [1:0] clc);
        @(negedge clk);
        rd_cmd  = 1'b1;
        rd_col  = CW'(9'h0A5);
        bl_code = blc;
        cl_code = clc;
        @(negedge clk);
        rd_cmd = 1'b0;
        chk("R7 mode_err pulse", int'(mode_err), 1);
        chk("R7 busy", int'(busy), 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 mode_err low", int'(mode_err), 0);
            chk("R7 no burst", int'({busy, dq_oe, dq_valid}), 0);
            chk("R10 col idle", int'(col_out), 0);
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", int'({dq_oe, dq_valid, busy, mode_err}), 0);
        chk("R10 reset col", int'(col_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", int'({dq_oe, dq_valid, busy, mode_err}), 0);
        for (int bs = 0; bs < 3; bs++)
            for (int il = 0; il < 2; il++)
                for (int cs = 0; cs < 2; cs++)
                    for (int s = 0; s < 8; s++) begin
                        run_burst(bs, il[0], cs[0], s, (s * 11 + bs * 7 + il * 3 + cs) & 63);
                        @(negedge clk);
                    end
        for (int b = 0; b < 8; b++)
            if (b == 0 || b > 3) bad_read(3'(b), 2'b10);
        bad_read(3'b010, 2'b00);
        bad_read(3'b011, 2'b01);
        run_burst(2, 1'b1, 1'b1, 5, 42);   // R2 example 5,4,7,6,1,0,3,2
        run_burst(1, 1'b0, 1'b0, 3, 17);   // R1 example 3,0,1,2
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule